// File: doc/BRIEF.md
# I2C Host Register and Interrupt Front End

This block is the software-facing side of an I2C host controller. A simple word-addressed bus writes transfer commands into a small command queue and reads received bytes out of a receive queue. The same bus sets the controller's enable, speed and queue threshold fields, the three bus timing counts, and the interrupt enables. A separate byte engine, not part of this block, drains the command queue, fills the receive queue and reports NACK and arbitration-loss events. The block combines these events and the two queue fill levels into five status flags and one level interrupt line.

Each command entry is 10 bits: bit 9 asks for a START before the byte, bit 8 asks for a STOP after it, and bits 7..0 carry the data or address byte. The two "ready" flags are levels computed from the queue fill levels and the programmed thresholds. The three error flags are sticky and are cleared by writing ones. Clearing the enable bit empties both queues and clears the error flags. A later re-enable therefore starts the controller from a clean state.

Both queues are `DEPTH` entries deep, 4 by default; `DEPTH` must be a power of two and at least 4. Read data is registered and is valid on the cycle after the read strobe.

Top module: `i2c_host_csr`

## Requirements
- R1: After reset, control, interrupt enable, status, both fill levels and the timing counts all read 0, and `irq` and `cmd_valid` are low.
- R2: A write to word offset 0x00 while enabled appends `bus_wdata[9:0]` to the command queue, and the level read at 0x18 increments. `cmd_data` presents the oldest entry while `cmd_valid` is high, and `cmd_pop` removes it. A write to a full queue is dropped and the level stays at `DEPTH`.
- R3: A read at 0x04 returns the oldest received byte in bits 7..0 and removes it, and the level read at 0x1C decrements. A read of an empty receive queue returns 0 and leaves the level at 0.
- R4: Status bit 0 (TX ready) is 1 exactly when the core is enabled and the command queue level is at most the command threshold held in control bits 3..2.
- R5: Status bit 1 (RX ready) is 1 exactly when the receive queue level is at least the receive threshold (control bits 5..4) plus one.
- R6: Status bit 2 (NACK) and bit 3 (arbitration lost) are set by one-cycle pulses on `evt_nack` and `evt_arb`. Each stays set until a status write (offset 0x10) carries a 1 in its position; writing 0 to it has no effect.
- R7: A receive byte arriving while the receive queue is full sets sticky status bit 4 (RX overflow), which is cleared by writing 1. The byte is discarded and the queued bytes are unchanged.
- R8: `irq` is high, one cycle after the cause, exactly when some status bit and the enable bit in the same position of the register at 0x0C are both 1.
- R9: While control bit 0 (enable) is 0, both queues are held empty and the sticky status bits are held clear. The interrupt enables and the timing counts keep their values.
- R10: Offsets 0x20, 0x24 and 0x28 hold the SCL low, SCL high and SDA hold counts, `TW` bits each, readable and driven on their outputs. Control bits 0 and 1 drive `core_en` and `fast_mode`.
- R11: Bit 0 of the core status word at 0x14 reads 1 when `eng_busy` is high or the command queue is not empty.
- R12: While disabled, command writes and `rx_push` are ignored. A read at an unmapped offset (0x2C and above) returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address; bits 1..0 ignored |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after `bus_rd` |
| cmd_valid | output | 1 | Command queue head available to the engine |
| cmd_data | output | 10 | Command head: START, STOP, byte |
| cmd_pop | input | 1 | Engine consumes the command head |
| rx_push | input | 1 | Engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| evt_nack | input | 1 | One-cycle NACK event from the engine |
| evt_arb | input | 1 | One-cycle arbitration-lost event |
| eng_busy | input | 1 | Engine is mid-transfer |
| core_en | output | 1 | Enable bit to the engine |
| fast_mode | output | 1 | Speed select to the timing generator |
| scl_low_cnt | output | TW | SCL low period count |
| scl_high_cnt | output | TW | SCL high period count |
| sda_hold_cnt | output | TW | SDA hold count |
| irq | output | 1 | Level interrupt, registered |

## Verification
The assertions assume that the byte engine raises `cmd_pop` only while `cmd_valid` is high, and that `bus_wr` and `bus_rd` are never active in the same cycle. The stimulus follows both rules. Every bus access lasts exactly one cycle, and engine pops are issued only after the bench has seen a queue entry present. The receive overflow case pushes into a full queue with no pop in the same cycle, so the discard is unambiguous.

// File: rtl/i2c_csr_pkg.sv
package i2c_csr_pkg;

  // word offsets (byte address >> 2)
  localparam int RG_CMD  = 0;
  localparam int RG_RXD  = 1;
  localparam int RG_CTRL = 2;
  localparam int RG_IEN  = 3;
  localparam int RG_STAT = 4;
  localparam int RG_BUSY = 5;
  localparam int RG_CLVL = 6;
  localparam int RG_RLVL = 7;
  localparam int RG_SCLL = 8;
  localparam int RG_SCLH = 9;
  localparam int RG_HOLD = 10;
  localparam int NUM_REGS = 11;

  // status / interrupt-enable bit positions
  localparam int ST_TXRDY = 0;
  localparam int ST_RXRDY = 1;
  localparam int ST_NACK  = 2;
  localparam int ST_ARB   = 3;
  localparam int ST_RXOF  = 4;
  localparam int ST_W     = 5;
  localparam int ERR_W    = 3;

  // command entry layout
  localparam int CMD_W     = 10;
  localparam int CMD_START = 9;
  localparam int CMD_STOP  = 8;

  localparam int THR_W  = 2;
  localparam int CTRL_W = 6;

  typedef struct packed {
    logic [THR_W-1:0] rx_thr;
    logic [THR_W-1:0] cmd_thr;
    logic             fast;
    logic             en;
  } ctrl_t;

endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode #(
  parameter int ADDR_W = 6,
  parameter int NREG   = 11
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic [NREG-1:0]   wr_sel,
  output logic [NREG-1:0]   rd_sel
);
  localparam int IW = ADDR_W - 2;

  logic [IW-1:0] word;
  assign word = addr[ADDR_W-1:2];

  for (genvar g = 0; g < NREG; g++) begin : g_sel
    assign wr_sel[g] = wr && (word == IW'(g));
    assign rd_sel[g] = rd && (word == IW'(g));
  end

endmodule

// File: rtl/csr_fifo.sv
module csr_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic                       push,
  input  logic                       pop,
  input  logic [W-1:0]               wdata,
  output logic [W-1:0]               head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty,
  output logic                       drop
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic [CNT_W-1:0] cnt_q;
  logic             pop_ok, push_ok;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign pop_ok  = pop && !empty && !flush;
  assign push_ok = push && !flush && (!full || pop_ok);
  assign drop    = push && !flush && full && !pop_ok;
  assign head    = empty ? '0 : mem[rptr];
  assign count   = cnt_q;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wptr <= wptr + 1'b1;
      if (pop_ok)  rptr <= rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(DEPTH));

  a_r2_full_drop: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !flush) |=> (cnt_q == CNT_W'(DEPTH)));

  a_r3_empty_pop_holds: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push) |=> (cnt_q == '0));

  a_r9_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> (cnt_q == '0));

endmodule

// File: rtl/csr_irq_unit.sv
module csr_irq_unit
  import i2c_csr_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             core_en,
  input  logic [CNT_W-1:0] cmd_lvl,
  input  logic [CNT_W-1:0] rx_lvl,
  input  logic [THR_W-1:0] cmd_thr,
  input  logic [THR_W-1:0] rx_thr,
  input  logic             ev_nack,
  input  logic             ev_arb,
  input  logic             ev_rxof,
  input  logic [ST_W-1:0]  w1c,
  input  logic [ST_W-1:0]  ien,
  output logic [ST_W-1:0]  status,
  output logic             irq
);
  logic [ERR_W-1:0] err_q;
  logic [ERR_W-1:0] set_v, clr_v;
  logic             tx_rdy, rx_rdy;
  logic             irq_q;

  assign set_v  = {ev_rxof, ev_arb, ev_nack};
  assign clr_v  = w1c[ST_RXOF:ST_NACK];
  assign tx_rdy = core_en && (cmd_lvl <= CNT_W'(cmd_thr));
  assign rx_rdy = (rx_lvl > CNT_W'(rx_thr));
  assign status = {err_q, rx_rdy, tx_rdy};
  assign irq    = irq_q;

  // a new event in the same cycle as its clear wins
  always_ff @(posedge clk) begin
    if (rst || !core_en) err_q <= '0;
    else                 err_q <= (err_q & ~clr_v) | set_v;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(status & ien);
  end

  a_r6_sticky_hold: assert property (@(posedge clk) disable iff (rst)
    (core_en && (w1c == '0)) |=> ((err_q & $past(err_q)) == $past(err_q)));

  a_r8_irq_masked: assert property (@(posedge clk) disable iff (rst)
    (ien == '0) |=> !irq_q);

  a_r9_disable_clears: assert property (@(posedge clk) disable iff (rst)
    !core_en |=> (err_q == '0));

endmodule

// File: rtl/i2c_host_csr.sv
module i2c_host_csr
  import i2c_csr_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int TW     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              cmd_valid,
  output logic [CMD_W-1:0]  cmd_data,
  input  logic              cmd_pop,
  input  logic              rx_push,
  input  logic [7:0]        rx_byte,
  input  logic              evt_nack,
  input  logic              evt_arb,
  input  logic              eng_busy,
  output logic              core_en,
  output logic              fast_mode,
  output logic [TW-1:0]     scl_low_cnt,
  output logic [TW-1:0]     scl_high_cnt,
  output logic [TW-1:0]     sda_hold_cnt,
  output logic              irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IW    = ADDR_W - 2;

  ctrl_t            ctrl_q;
  logic [ST_W-1:0]  ien_q;
  logic [TW-1:0]    scll_q, sclh_q, hold_q;
  logic [DATA_W-1:0] rdata_q, rd_mux;

  logic [NUM_REGS-1:0] wr_sel, rd_sel;
  logic [IW-1:0]       word;

  logic [CMD_W-1:0] cmd_head;
  logic [CNT_W-1:0] cmd_lvl, rx_lvl;
  logic             cmd_full, cmd_empty, cmd_drop;
  logic [7:0]       rx_head;
  logic             rx_full, rx_empty, rx_drop;
  logic [ST_W-1:0]  status, w1c;
  logic             flush;

  assign word  = bus_addr[ADDR_W-1:2];
  assign flush = !ctrl_q.en;

  csr_addr_decode #(.ADDR_W(ADDR_W), .NREG(NUM_REGS)) u_dec (
    .addr   (bus_addr),
    .wr     (bus_wr),
    .rd     (bus_rd),
    .wr_sel (wr_sel),
    .rd_sel (rd_sel)
  );

  csr_fifo #(.W(CMD_W), .DEPTH(DEPTH)) u_cmdq (
    .clk   (clk),
    .rst   (rst),
    .flush (flush),
    .push  (wr_sel[RG_CMD]),
    .pop   (cmd_pop),
    .wdata (bus_wdata[CMD_W-1:0]),
    .head  (cmd_head),
    .count (cmd_lvl),
    .full  (cmd_full),
    .empty (cmd_empty),
    .drop  (cmd_drop)
  );

  csr_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
    .clk   (clk),
    .rst   (rst),
    .flush (flush),
    .push  (rx_push),
    .pop   (rd_sel[RG_RXD]),
    .wdata (rx_byte),
    .head  (rx_head),
    .count (rx_lvl),
    .full  (rx_full),
    .empty (rx_empty),
    .drop  (rx_drop)
  );

  assign w1c = wr_sel[RG_STAT] ? bus_wdata[ST_W-1:0] : '0;

  csr_irq_unit #(.CNT_W(CNT_W)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .core_en (ctrl_q.en),
    .cmd_lvl (cmd_lvl),
    .rx_lvl  (rx_lvl),
    .cmd_thr (ctrl_q.cmd_thr),
    .rx_thr  (ctrl_q.rx_thr),
    .ev_nack (evt_nack),
    .ev_arb  (evt_arb),
    .ev_rxof (rx_drop),
    .w1c     (w1c),
    .ien     (ien_q),
    .status  (status),
    .irq     (irq)
  );

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      ien_q  <= '0;
      scll_q <= '0;
      sclh_q <= '0;
      hold_q <= '0;
    end else begin
      if (wr_sel[RG_CTRL]) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (wr_sel[RG_IEN])  ien_q  <= bus_wdata[ST_W-1:0];
      if (wr_sel[RG_SCLL]) scll_q <= bus_wdata[TW-1:0];
      if (wr_sel[RG_SCLH]) sclh_q <= bus_wdata[TW-1:0];
      if (wr_sel[RG_HOLD]) hold_q <= bus_wdata[TW-1:0];
    end
  end

  // read path
  always_comb begin
    rd_mux = '0;
    case (word)
      IW'(RG_RXD):  rd_mux = DATA_W'(rx_head);
      IW'(RG_CTRL): rd_mux = DATA_W'(ctrl_q);
      IW'(RG_IEN):  rd_mux = DATA_W'(ien_q);
      IW'(RG_STAT): rd_mux = DATA_W'(status);
      IW'(RG_BUSY): rd_mux = DATA_W'(eng_busy || !cmd_empty);
      IW'(RG_CLVL): rd_mux = DATA_W'(cmd_lvl);
      IW'(RG_RLVL): rd_mux = DATA_W'(rx_lvl);
      IW'(RG_SCLL): rd_mux = DATA_W'(scll_q);
      IW'(RG_SCLH): rd_mux = DATA_W'(sclh_q);
      IW'(RG_HOLD): rd_mux = DATA_W'(hold_q);
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign bus_rdata    = rdata_q;
  assign cmd_valid    = ctrl_q.en && !cmd_empty;
  assign cmd_data     = cmd_head;
  assign core_en      = ctrl_q.en;
  assign fast_mode    = ctrl_q.fast;
  assign scl_low_cnt  = scll_q;
  assign scl_high_cnt = sclh_q;
  assign sda_hold_cnt = hold_q;

  a_r3_empty_read_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_sel[RG_RXD] && rx_empty) |=> (bus_rdata == '0));

  a_r11_busy_reads_one: assert property (@(posedge clk) disable iff (rst)
    (rd_sel[RG_BUSY] && eng_busy) |=> bus_rdata[0]);

  a_r12_off_no_push: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.en && !wr_sel[RG_CTRL]) |=> !cmd_valid);

endmodule

// File: tb/sim_i2c_host_csr.sv
module sim_i2c_host_csr;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_wr, bus_rd;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        cmd_valid, cmd_pop;
  logic [9:0]  cmd_data;
  logic        rx_push;
  logic [7:0]  rx_byte;
  logic        evt_nack, evt_arb, eng_busy;
  logic        core_en, fast_mode, irq;
  logic [15:0] scl_low_cnt, scl_high_cnt, sda_hold_cnt;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  i2c_host_csr #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_pop(cmd_pop),
    .rx_push(rx_push), .rx_byte(rx_byte), .evt_nack(evt_nack),
    .evt_arb(evt_arb), .eng_busy(eng_busy), .core_en(core_en),
    .fast_mode(fast_mode), .scl_low_cnt(scl_low_cnt),
    .scl_high_cnt(scl_high_cnt), .sda_hold_cnt(sda_hold_cnt), .irq(irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic eng_rx(input logic [7:0] b);
    @(negedge clk);
    rx_push = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_push = 1'b0;
  endtask

  task automatic eng_pop();
    @(negedge clk);
    cmd_pop = 1'b1;
    @(negedge clk);
    cmd_pop = 1'b0;
  endtask

  task automatic pulse_nack();
    @(negedge clk); evt_nack = 1'b1;
    @(negedge clk); evt_nack = 1'b0;
  endtask

  task automatic pulse_arb();
    @(negedge clk); evt_arb = 1'b1;
    @(negedge clk); evt_arb = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(6'h08, d); chk("R1", "ctrl", d, 0);
    rd(6'h0C, d); chk("R1", "ien", d, 0);
    rd(6'h10, d); chk("R1", "status", d, 0);
    rd(6'h18, d); chk("R1", "cmd level", d, 0);
    rd(6'h1C, d); chk("R1", "rx level", d, 0);
    rd(6'h20, d); chk("R1", "scl low", d, 0);
    chk("R1", "irq", irq, 0);
    chk("R1", "cmd_valid", cmd_valid, 0);
  endtask

  task automatic t_timing();
    logic [31:0] d;
    wr(6'h20, 32'h0001_1234);
    wr(6'h24, 32'h0000_ABCD);
    wr(6'h28, 32'h0000_0042);
    rd(6'h20, d); chk("R10", "scl low readback", d, 32'h1234);
    rd(6'h24, d); chk("R10", "scl high readback", d, 32'hABCD);
    rd(6'h28, d); chk("R10", "hold readback", d, 32'h42);
    chk("R10", "scl_low_cnt", scl_low_cnt, 32'h1234);
    chk("R10", "sda_hold_cnt", sda_hold_cnt, 32'h42);
    wr(6'h08, 32'h03);
    chk("R10", "core_en", core_en, 1);
    chk("R10", "fast_mode", fast_mode, 1);
    rd(6'h2C, d); chk("R12", "unmapped read", d, 0);
    wr(6'h08, 32'h00);
  endtask

  task automatic t_cmd();
    logic [31:0] d;
    wr(6'h08, 32'h01);
    rd(6'h14, d); chk("R11", "idle core status", d, 0);
    wr(6'h00, 32'h2A5);
    wr(6'h00, 32'h011);
    wr(6'h00, 32'h122);
    rd(6'h18, d); chk("R2", "level after 3", d, 3);
    chk("R2", "cmd_valid", cmd_valid, 1);
    chk("R2", "head", cmd_data, 32'h2A5);
    rd(6'h14, d); chk("R11", "status queue nonempty", d, 1);
    wr(6'h00, 32'h033);
    wr(6'h00, 32'h0EE);
    rd(6'h18, d); chk("R2", "level full, extra dropped", d, DEPTH);
    eng_pop(); chk("R2", "second head", cmd_data, 32'h011);
    eng_pop(); chk("R2", "third head", cmd_data, 32'h122);
    eng_pop(); chk("R2", "fourth head", cmd_data, 32'h033);
    eng_pop(); chk("R2", "drained valid", cmd_valid, 0);
    rd(6'h18, d); chk("R2", "level drained", d, 0);
    eng_busy = 1'b1;
    rd(6'h14, d); chk("R11", "engine busy", d, 1);
    eng_busy = 1'b0;
  endtask

  task automatic t_txrdy();
    logic [31:0] d;
    wr(6'h08, 32'h09);
    rd(6'h10, d); chk("R4", "txrdy empty thr2", d & 32'h1, 1);
    wr(6'h00, 32'h01); wr(6'h00, 32'h02);
    rd(6'h10, d); chk("R4", "txrdy level2 thr2", d & 32'h1, 1);
    wr(6'h00, 32'h03);
    rd(6'h10, d); chk("R4", "txrdy level3 thr2", d & 32'h1, 0);
    eng_pop();
    rd(6'h10, d); chk("R4", "txrdy after pop", d & 32'h1, 1);
    wr(6'h08, 32'h00);
    rd(6'h10, d); chk("R4", "txrdy disabled", d & 32'h1, 0);
  endtask

  task automatic t_rx();
    logic [31:0] d;
    wr(6'h08, 32'h11);
    eng_rx(8'h11);
    rd(6'h10, d); chk("R5", "rxrdy level1 thr1", d & 32'h2, 0);
    eng_rx(8'h22);
    rd(6'h10, d); chk("R5", "rxrdy level2 thr1", d & 32'h2, 2);
    rd(6'h1C, d); chk("R3", "rx level", d, 2);
    rd(6'h04, d); chk("R3", "first byte", d, 32'h11);
    rd(6'h1C, d); chk("R3", "rx level after pop", d, 1);
    rd(6'h04, d); chk("R3", "second byte", d, 32'h22);
    rd(6'h04, d); chk("R3", "empty pop", d, 0);
    rd(6'h1C, d); chk("R3", "level after empty pop", d, 0);
    wr(6'h08, 32'h00);
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    wr(6'h08, 32'h01);
    wr(6'h0C, 32'h04);
    pulse_nack();
    @(negedge clk);
    rd(6'h10, d); chk("R6", "nack set", d & 32'h1C, 32'h04);
    chk("R8", "irq on enabled nack", irq, 1);
    wr(6'h10, 32'h00);
    rd(6'h10, d); chk("R6", "write 0 keeps", d & 32'h1C, 32'h04);
    wr(6'h10, 32'h08);
    rd(6'h10, d); chk("R6", "other bit w1c keeps", d & 32'h1C, 32'h04);
    wr(6'h10, 32'h04);
    rd(6'h10, d); chk("R6", "w1c clears nack", d & 32'h1C, 0);
    @(negedge clk);
    chk("R8", "irq drops", irq, 0);
    pulse_arb();
    @(negedge clk);
    rd(6'h10, d); chk("R6", "arb set", d & 32'h1C, 32'h08);
    chk("R8", "irq masked arb", irq, 0);
    wr(6'h0C, 32'h08);
    @(negedge clk);
    chk("R8", "irq after enabling arb", irq, 1);
    wr(6'h10, 32'h08);
    wr(6'h0C, 32'h00);
  endtask

  task automatic t_rxof();
    logic [31:0] d;
    for (int i = 0; i < DEPTH + 1; i++) eng_rx(8'hA0 + 8'(i));
    rd(6'h10, d); chk("R7", "overflow flag", d & 32'h10, 32'h10);
    rd(6'h1C, d); chk("R7", "level full", d, DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      rd(6'h04, d); chk("R7", "kept byte", d, 32'hA0 + i);
    end
    rd(6'h04, d); chk("R7", "dropped byte absent", d, 0);
    wr(6'h10, 32'h10);
    rd(6'h10, d); chk("R7", "overflow w1c", d & 32'h10, 0);
  endtask

  task automatic t_flush();
    logic [31:0] d;
    wr(6'h0C, 32'h1C);
    wr(6'h00, 32'h055); wr(6'h00, 32'h066);
    eng_rx(8'h77);
    pulse_nack();
    wr(6'h08, 32'h00);
    rd(6'h18, d); chk("R9", "cmd flushed", d, 0);
    rd(6'h1C, d); chk("R9", "rx flushed", d, 0);
    rd(6'h10, d); chk("R9", "sticky cleared", d, 0);
    rd(6'h0C, d); chk("R9", "ien kept", d, 32'h1C);
    rd(6'h24, d); chk("R9", "timing kept", d, 32'hABCD);
    wr(6'h00, 32'h099);
    eng_rx(8'h88);
    rd(6'h18, d); chk("R12", "cmd write ignored off", d, 0);
    rd(6'h1C, d); chk("R12", "rx push ignored off", d, 0);
    wr(6'h08, 32'h01);
    chk("R9", "clean after re-enable", cmd_valid, 0);
    rd(6'h1C, d); chk("R9", "rx empty after re-enable", d, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    cmd_pop = 0; rx_push = 0; rx_byte = '0; evt_nack = 0; evt_arb = 0;
    eng_busy = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_timing();
    t_cmd();
    t_txrdy();
    t_rx();
    t_sticky();
    t_rxof();
    t_flush();
    finish_run();
  end

endmodule